// File: doc/BRIEF.md
# Control IN Endpoint Transfer Size Tracker

This block holds the transfer-size and packet-count register of a USB device control IN endpoint. Software loads a packet count and a byte count through a simple register write port while the endpoint is idle, then raises a one-cycle enable request. While the endpoint is enabled, the block owns the register. Each packet that the packet engine pulls from the transmit FIFO takes one from the packet count and that packet's length from the byte count. This holds for full-size and short packets alike.

A small state machine has three states. In ST_IDLE the endpoint is disabled and the register is writable. In ST_ARMED the endpoint is enabled and the counters run. ST_FINISH lasts one cycle and marks a completed transfer. The transitions are as follows:

- ARM (ST_IDLE to ST_ARMED) happens on an enable request.
- LAST (ST_ARMED to ST_FINISH) happens on a packet read that takes the packet count from one to zero.
- FAULT (ST_ARMED to ST_IDLE) happens on a packet read that arrives with the count already at zero.
- RETIRE (ST_FINISH to ST_IDLE) always follows ST_FINISH.
- HOLD keeps ST_ARMED in every other case.

An enable request in ST_FINISH is dropped.

Top module: `ep_xfer_tracker`

## Requirements
- R1: After reset, `reg_rdata` is 0, and `ep_enabled`, `xfer_done` and `pkt_err` are all 0.
- R2: The packet count sits at `reg_rdata[20:19]` and the byte count at `reg_rdata[6:0]`. All other bits read 0. A `reg_wr` while the endpoint is disabled loads both fields from the same positions of `reg_wdata`, and the new values are visible in the next cycle.
- R3: A `reg_wr` while `ep_enabled` is 1 leaves both fields unchanged.
- R4: An `ep_en_set` pulse while disabled sets `ep_enabled` in the next cycle. An `ep_en_set` while enabled has no visible effect.
- R5: Each `pkt_rd` while enabled with a nonzero packet count lowers the packet count by exactly one, whatever `pkt_len` is.
- R6: The same `pkt_rd` subtracts `pkt_len` from the byte count, which stops at 0 rather than wrapping.
- R7: When a `pkt_rd` takes the packet count to 0, `ep_enabled` drops and `xfer_done` is 1 in the next cycle. `xfer_done` is 1 for exactly that one cycle.
- R8: A `pkt_rd` while enabled with the packet count already 0 leaves both fields unchanged. It sets `pkt_err`, drops `ep_enabled` in the next cycle and does not raise `xfer_done`.
- R9: A `pkt_rd` while disabled changes no field and does not set `pkt_err`.
- R10: `pkt_err` stays set until an `ep_en_set` is accepted, which clears it in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value |
| ep_en_set | input | 1 | Endpoint enable request pulse |
| ep_enabled | output | 1 | Endpoint enabled (controller owns the register) |
| pkt_rd | input | 1 | One packet pulled from the transmit FIFO |
| pkt_len | input | 7 | Byte length of the packet being pulled |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |
| pkt_err | output | 1 | Sticky flag: packet read with the count at zero |

## Verification
The bench builds the block with its default parameters: a 2-bit packet count at bit 19 and a 7-bit byte count. The small packet field makes every count value, including the full count of three and the step into zero, reachable in a few packets. The narrow byte field lets one short packet drive the byte count into saturation. Both fields written as all ones expose the field positions and the reserved zeros in a single readback.

// File: rtl/ep_xfer_pkg.sv
package ep_xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_FINISH = 2'd2
    } ep_state_e;

endpackage

// File: rtl/ep_down_cnt.sv
module ep_down_cnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    input  logic [W-1:0] dec_amt,
    output logic [W-1:0] cnt,
    output logic         is_zero,
    output logic         is_one
);

    logic [W-1:0] cnt_next;
    logic         underflow;

    // saturating subtract: a step larger than the remainder lands on zero
    always_comb begin
        underflow = (dec_amt >= cnt);
        cnt_next  = cnt;
        if (load) begin
            cnt_next = load_val;
        end else if (dec) begin
            cnt_next = underflow ? '0 : (cnt - dec_amt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_next;
        end
    end

    assign is_zero = (cnt == '0);
    assign is_one  = (cnt == W'(1));

endmodule

// File: rtl/ep_xfer_fsm.sv
module ep_xfer_fsm
    import ep_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic pkt_rd,
    input  logic reg_wr,
    input  logic pkt_zero,
    input  logic pkt_one,
    output logic ep_enabled,
    output logic xfer_done,
    output logic pkt_err,
    output logic cnt_dec,
    output logic sw_load
);

    ep_state_e state_q;
    ep_state_e state_d;
    logic      err_q;
    logic      err_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_req) begin
                    state_d = ST_ARMED;            // ARM
                end
            end
            ST_ARMED: begin
                if (pkt_rd && pkt_zero) begin
                    state_d = ST_IDLE;             // FAULT
                end else if (pkt_rd && pkt_one) begin
                    state_d = ST_FINISH;           // LAST
                end else begin
                    state_d = ST_ARMED;            // HOLD
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;                 // RETIRE
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // sticky error: set on FAULT, cleared when ARM is taken
    always_comb begin
        err_d = err_q;
        if (state_q == ST_IDLE && en_req) begin
            err_d = 1'b0;
        end else if (state_q == ST_ARMED && pkt_rd && pkt_zero) begin
            err_d = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    // outputs
    always_comb begin
        ep_enabled = 1'b0;
        xfer_done  = 1'b0;
        cnt_dec    = 1'b0;
        sw_load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                sw_load = reg_wr;
            end
            ST_ARMED: begin
                ep_enabled = 1'b1;
                cnt_dec    = pkt_rd && !pkt_zero;
            end
            ST_FINISH: begin
                xfer_done = 1'b1;
                sw_load   = reg_wr;
            end
            default: begin
                ep_enabled = 1'b0;
            end
        endcase
    end

    assign pkt_err = err_q;

endmodule

// File: rtl/ep_xfer_rdmux.sv
module ep_xfer_rdmux #(
    parameter int REG_W   = 32,
    parameter int PKT_W   = 2,
    parameter int PKT_LSB = 19,
    parameter int SIZE_W  = 7
) (
    input  logic [PKT_W-1:0]  pkt_cnt,
    input  logic [SIZE_W-1:0] byte_cnt,
    output logic [REG_W-1:0]  rdata
);

    localparam int PKT_MSB = PKT_LSB + PKT_W - 1;

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (b >= PKT_LSB && b <= PKT_MSB) begin : g_pkt
            assign rdata[b] = pkt_cnt[b-PKT_LSB];
        end else if (b < SIZE_W) begin : g_size
            assign rdata[b] = byte_cnt[b];
        end else begin : g_rsvd
            assign rdata[b] = 1'b0;
        end
    end

endmodule

// File: rtl/ep_xfer_tracker.sv
module ep_xfer_tracker #(
    parameter int REG_W   = 32,
    parameter int PKT_W   = 2,
    parameter int PKT_LSB = 19,
    parameter int SIZE_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ep_en_set,
    output logic              ep_enabled,
    input  logic              pkt_rd,
    input  logic [SIZE_W-1:0] pkt_len,
    output logic              xfer_done,
    output logic              pkt_err
);

    localparam int PKT_MSB = PKT_LSB + PKT_W - 1;

    logic [PKT_W-1:0]  pkt_cnt;
    logic [SIZE_W-1:0] byte_cnt;
    logic              pkt_zero;
    logic              pkt_one;
    logic              byte_zero_unused;
    logic              byte_one_unused;
    logic              cnt_dec;
    logic              sw_load;

    ep_xfer_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_req     (ep_en_set),
        .pkt_rd     (pkt_rd),
        .reg_wr     (reg_wr),
        .pkt_zero   (pkt_zero),
        .pkt_one    (pkt_one),
        .ep_enabled (ep_enabled),
        .xfer_done  (xfer_done),
        .pkt_err    (pkt_err),
        .cnt_dec    (cnt_dec),
        .sw_load    (sw_load)
    );

    ep_down_cnt #(.W(PKT_W)) u_pkt_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sw_load),
        .load_val (reg_wdata[PKT_MSB:PKT_LSB]),
        .dec      (cnt_dec),
        .dec_amt  (PKT_W'(1)),
        .cnt      (pkt_cnt),
        .is_zero  (pkt_zero),
        .is_one   (pkt_one)
    );

    ep_down_cnt #(.W(SIZE_W)) u_byte_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sw_load),
        .load_val (reg_wdata[SIZE_W-1:0]),
        .dec      (cnt_dec),
        .dec_amt  (pkt_len),
        .cnt      (byte_cnt),
        .is_zero  (byte_zero_unused),
        .is_one   (byte_one_unused)
    );

    ep_xfer_rdmux #(
        .REG_W   (REG_W),
        .PKT_W   (PKT_W),
        .PKT_LSB (PKT_LSB),
        .SIZE_W  (SIZE_W)
    ) u_rdmux (
        .pkt_cnt  (pkt_cnt),
        .byte_cnt (byte_cnt),
        .rdata    (reg_rdata)
    );

endmodule

// File: rtl/ep_xfer_tracker_chk.sv
module ep_xfer_tracker_chk #(
    parameter int REG_W   = 32,
    parameter int PKT_W   = 2,
    parameter int PKT_LSB = 19,
    parameter int SIZE_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              ep_en_set,
    input logic              ep_enabled,
    input logic              pkt_rd,
    input logic [SIZE_W-1:0] pkt_len,
    input logic              xfer_done,
    input logic              pkt_err
);

    logic [PKT_W-1:0] pkt_f;
    assign pkt_f = reg_rdata[PKT_LSB +: PKT_W];

    AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ep_enabled && reg_wr && !pkt_rd |=> $stable(reg_rdata)); // R3

    AST_PKT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ep_enabled && pkt_rd && pkt_f != '0 |=> pkt_f == PKT_W'($past(pkt_f) - 1'b1)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done); // R7

    AST_DONE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !ep_enabled && pkt_f == '0); // R7

    AST_ZERO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ep_enabled && pkt_rd && pkt_f == '0 |=> pkt_err && !ep_enabled && !xfer_done && $stable(reg_rdata)); // R8

    AST_IDLE_RD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_enabled && !reg_wr && pkt_rd |=> $stable(reg_rdata)); // R9

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_enabled && !xfer_done && ep_en_set |=> !pkt_err && ep_enabled); // R10

endmodule

bind ep_xfer_tracker ep_xfer_tracker_chk #(
    .REG_W   (REG_W),
    .PKT_W   (PKT_W),
    .PKT_LSB (PKT_LSB),
    .SIZE_W  (SIZE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ep_en_set  (ep_en_set),
    .ep_enabled (ep_enabled),
    .pkt_rd     (pkt_rd),
    .pkt_len    (pkt_len),
    .xfer_done  (xfer_done),
    .pkt_err    (pkt_err)
);

// File: tb/ep_xfer_tracker_bench.sv
module ep_xfer_tracker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ep_en_set = 1'b0;
    logic        ep_enabled;
    logic        pkt_rd = 1'b0;
    logic [6:0]  pkt_len = '0;
    logic        xfer_done;
    logic        pkt_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ep_xfer_tracker u_ep_xfer_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ep_en_set  (ep_en_set),
        .ep_enabled (ep_enabled),
        .pkt_rd     (pkt_rd),
        .pkt_len    (pkt_len),
        .xfer_done  (xfer_done),
        .pkt_err    (pkt_err)
    );

    function automatic logic [31:0] reg_val(input int pkts, input int bytes);
        return (32'(pkts & 3) << 19) | 32'(bytes & 8'h7f);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive inputs for one clock edge, return at the following negedge
    task automatic step(input logic wr, input logic [31:0] wd, input logic en,
                        input logic rd, input logic [6:0] len);
        reg_wr = wr; reg_wdata = wd; ep_en_set = en; pkt_rd = rd; pkt_len = len;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; ep_en_set = 1'b0; pkt_rd = 1'b0; pkt_len = '0;
    endtask

    task automatic t_reset();
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 enabled", 32'(ep_enabled), 32'h0);
        chk("R1 done", 32'(xfer_done), 32'h0);
        chk("R1 err", 32'(pkt_err), 32'h0);
    endtask

    task automatic t_readback();
        step(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, '0);
        chk("R2 all-ones layout", reg_rdata, 32'h0018_007F);
        step(1'b1, reg_val(2, 100), 1'b0, 1'b0, '0);
        chk("R2 load", reg_rdata, reg_val(2, 100));
    endtask

    task automatic t_disabled_read();
        step(1'b0, '0, 1'b0, 1'b1, 7'd40);
        chk("R9 fields kept", reg_rdata, reg_val(2, 100));
        chk("R9 no err", 32'(pkt_err), 32'h0);
    endtask

    task automatic t_full_transfer();
        step(1'b1, reg_val(2, 100), 1'b0, 1'b0, '0);
        step(1'b0, '0, 1'b1, 1'b0, '0);
        chk("R4 enabled", 32'(ep_enabled), 32'h1);
        step(1'b0, '0, 1'b0, 1'b1, 7'd64);
        chk("R5 R6 first packet", reg_rdata, reg_val(1, 36));
        chk("R7 not done yet", 32'(xfer_done), 32'h0);
        step(1'b1, reg_val(3, 5), 1'b0, 1'b0, '0);
        chk("R3 write blocked", reg_rdata, reg_val(1, 36));
        step(1'b0, '0, 1'b1, 1'b0, '0);
        chk("R4 re-enable no effect", reg_rdata, reg_val(1, 36));
        chk("R4 still enabled", 32'(ep_enabled), 32'h1);
        step(1'b0, '0, 1'b0, 1'b1, 7'd36);
        chk("R7 done pulse", 32'(xfer_done), 32'h1);
        chk("R7 disabled", 32'(ep_enabled), 32'h0);
        chk("R7 fields zero", reg_rdata, reg_val(0, 0));
        step(1'b0, '0, 1'b0, 1'b0, '0);
        chk("R7 pulse one cycle", 32'(xfer_done), 32'h0);
    endtask

    task automatic t_short_packets();
        step(1'b1, reg_val(3, 10), 1'b0, 1'b0, '0);
        step(1'b0, '0, 1'b1, 1'b0, '0);
        step(1'b0, '0, 1'b0, 1'b1, 7'd5);
        chk("R5 R6 short", reg_rdata, reg_val(2, 5));
        step(1'b0, '0, 1'b0, 1'b1, 7'd20);
        chk("R6 saturate", reg_rdata, reg_val(1, 0));
        chk("R5 enabled mid", 32'(ep_enabled), 32'h1);
        step(1'b0, '0, 1'b0, 1'b1, 7'd0);
        chk("R5 zero-length last", reg_rdata, reg_val(0, 0));
        chk("R7 done short", 32'(xfer_done), 32'h1);
        step(1'b0, '0, 1'b0, 1'b0, '0);
    endtask

    task automatic t_zero_count();
        step(1'b1, reg_val(0, 5), 1'b0, 1'b0, '0);
        step(1'b0, '0, 1'b1, 1'b0, '0);
        step(1'b0, '0, 1'b0, 1'b1, 7'd3);
        chk("R8 err", 32'(pkt_err), 32'h1);
        chk("R8 disabled", 32'(ep_enabled), 32'h0);
        chk("R8 no done", 32'(xfer_done), 32'h0);
        chk("R8 fields kept", reg_rdata, reg_val(0, 5));
        step(1'b0, '0, 1'b0, 1'b1, 7'd3);
        chk("R10 err sticky", 32'(pkt_err), 32'h1);
        chk("R9 idle read ignored", reg_rdata, reg_val(0, 5));
        step(1'b1, reg_val(1, 8), 1'b0, 1'b0, '0);
        chk("R10 err kept after write", 32'(pkt_err), 32'h1);
        step(1'b0, '0, 1'b1, 1'b0, '0);
        chk("R10 err cleared", 32'(pkt_err), 32'h0);
        step(1'b0, '0, 1'b0, 1'b1, 7'd8);
        chk("R7 single packet done", 32'(xfer_done), 32'h1);
        step(1'b0, '0, 1'b0, 1'b0, '0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_readback();
        t_disabled_read();
        t_full_transfer();
        t_short_packets();
        t_zero_count();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule